// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data ports, A and B, of `WIDTH` bits each. Each direction has its own capture register with its own rising-edge clock. The AB register samples port A on `clk_ab`, and the BA register samples port B on `clk_ba`. Capture happens on every edge, whatever the output controls are doing. A port can therefore be loaded while the other side is being driven, or while both sides float.

An active-low output enable and a direction input pick which port the block drives: none, A or B. Each side has a select input. It chooses between live data from the opposite port and the stored contents of that direction's register. The output path is built non-inverting or inverting by a parameter.

Tri-state pins are split into an input vector, an output vector and a drive-enable for each port. The surrounding logic resolves the real bus from these signals.

Top module: `dual_reg_xcvr`

## Requirements
- R1: An active-low `rst_n` asynchronously clears both capture registers to zero, so a stored-data selection right after reset presents all zeros, after polarity.
- R2: Every rising edge of `clk_ab` loads `a_in` into the AB register, regardless of `oe_n` and `dir_to_b`.
- R3: Every rising edge of `clk_ba` loads `b_in` into the BA register, regardless of `oe_n` and `dir_to_b`.
- R4: While `oe_n` is 1, both `a_drive` and `b_drive` are 0.
- R5: With `oe_n` = 0 and `dir_to_b` = 0, `a_drive` is 1 and `b_drive` is 0.
- R6: With `oe_n` = 0 and `dir_to_b` = 1, `b_drive` is 1 and `a_drive` is 0. At no time are both drive-enables 1.
- R7: While port A is driven, `a_sel_stored` = 0 puts live `b_in` on `a_out`, and `a_sel_stored` = 1 puts the BA register on `a_out`.
- R8: While port B is driven, `b_sel_stored` = 0 puts live `a_in` on `b_out`, and `b_sel_stored` = 1 puts the AB register on `b_out`.
- R9: With `INVERT` = 1, the driven port carries the bitwise complement of the selected data. With `INVERT` = 0, it carries the selected data unchanged.
- R10: A change of a select input or of live input data reaches the driven output in the same cycle, through no register.
- R11: A port output vector whose drive-enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Rising edge loads the AB register from port A |
| clk_ba | input | 1 | Rising edge loads the BA register from port B |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| oe_n | input | 1 | Active-low output enable |
| dir_to_b | input | 1 | 1: drive port B, 0: drive port A |
| a_sel_stored | input | 1 | Source for port A: 0 live B, 1 BA register |
| b_sel_stored | input | 1 | Source for port B: 0 live A, 1 AB register |
| a_in | input | WIDTH | Resolved value present on port A |
| a_out | output | WIDTH | Data the block places on port A |
| a_drive | output | 1 | Drive-enable for port A |
| b_in | input | WIDTH | Resolved value present on port B |
| b_out | output | WIDTH | Data the block places on port B |
| b_drive | output | 1 | Drive-enable for port B |

## Verification
A wrong capture register stays hidden until a stored-data selection drives its port. From that moment it shows on the output in the same cycle. The bench therefore loads values with outputs idle or pointed the other way, and then reads them back through the stored path. A fault in direction or enable decoding shows at once on the drive-enables. A polarity fault shows on every driven value, and building both variants side by side exposes it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;

   typedef enum logic {
      TOWARD_A = 1'b0,
      TOWARD_B = 1'b1
   } dir_e;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   // R2 / R3: each edge stores the port value present at that edge
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q == $past(d)))
      else $error("capture register missed its input");

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic             en,
   input  xcvr_pkg::src_e   src,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic             drive,
   output logic [WIDTH-1:0] dout
);
   import xcvr_pkg::*;

   logic [WIDTH-1:0] picked;
   logic [WIDTH-1:0] shaped;

   always_comb picked = (src == SRC_STORED) ? stored : live;

   generate
      if (INVERT) begin : g_inv
         always_comb shaped = ~picked;
      end else begin : g_pass
         always_comb shaped = picked;
      end
   endgenerate

   always_comb begin
      drive = en;
      dout  = en ? shaped : '0;
   end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst_n,
   input  logic             oe_n,
   input  logic             dir_to_b,
   input  logic             a_sel_stored,
   input  logic             b_sel_stored,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drive,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drive
);
   import xcvr_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be at least 1");
      end
   endgenerate

   logic [MSB:0] held_ab;
   logic [MSB:0] held_ba;
   logic         en_a;
   logic         en_b;
   dir_e         dir;

   always_comb begin
      dir  = dir_e'(dir_to_b);
      en_a = !oe_n && (dir == TOWARD_A);
      en_b = !oe_n && (dir == TOWARD_B);
   end

   xcvr_capture #(.WIDTH(WIDTH)) u_reg_ab (
      .clk  (clk_ab),
      .rst_n(rst_n),
      .d    (a_in),
      .q    (held_ab)
   );

   xcvr_capture #(.WIDTH(WIDTH)) u_reg_ba (
      .clk  (clk_ba),
      .rst_n(rst_n),
      .d    (b_in),
      .q    (held_ba)
   );

   xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_drv_a (
      .en    (en_a),
      .src   (src_e'(a_sel_stored)),
      .live  (b_in),
      .stored(held_ba),
      .drive (a_drive),
      .dout  (a_out)
   );

   xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_drv_b (
      .en    (en_b),
      .src   (src_e'(b_sel_stored)),
      .live  (a_in),
      .stored(held_ab),
      .drive (b_drive),
      .dout  (b_out)
   );

   always_comb begin
      p_single_port_r6: assert (!(a_drive && b_drive))
         else $error("both ports driven");
      p_idle_r4: assert (!oe_n || (!a_drive && !b_drive))
         else $error("port driven while disabled");
      p_quiet_a_r11: assert (a_drive || (a_out == '0))
         else $error("undriven A output not zero");
      p_quiet_b_r11: assert (b_drive || (b_out == '0))
         else $error("undriven B output not zero");
   end

endmodule

// File: tb/sim_dual_reg_xcvr.sv
module sim_dual_reg_xcvr;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int W = 8;

   typedef struct {
      logic         ad;
      logic [W-1:0] adat;
      logic         bd;
      logic [W-1:0] bdat;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
   logic         oe_n = 1'b1, dir_to_b = 1'b0, a_sel = 1'b0, b_sel = 1'b0;
   logic [W-1:0] a_ext = '0, b_ext = '0;
   logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
   logic         a_drv0, b_drv0, a_drv1, b_drv1;

   logic [W-1:0] mdl_ab = '0, mdl_ba = '0;
   exp_t         sb[$];
   int           checks = 0, errors = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b1)) u0 (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n),
      .dir_to_b(dir_to_b), .a_sel_stored(a_sel), .b_sel_stored(b_sel),
      .a_in(a_ext), .a_out(a_out0), .a_drive(a_drv0),
      .b_in(b_ext), .b_out(b_out0), .b_drive(b_drv0));

   dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b0)) u1 (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n),
      .dir_to_b(dir_to_b), .a_sel_stored(a_sel), .b_sel_stored(b_sel),
      .a_in(a_ext), .a_out(a_out1), .a_drive(a_drv1),
      .b_in(b_ext), .b_out(b_out1), .b_drive(b_drv1));

   function automatic logic [W-1:0] shape(logic d, logic [W-1:0] v, bit inv);
      if (!d) return '0;              // R11
      return inv ? ~v : v;            // R9
   endfunction

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic cmp(string tag, string who, logic [W+W+1:0] act, logic [W+W+1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
      end
   endtask

   // monitor: pops one expected item per clock and compares both builds
   always @(posedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         cmp(e.tag, "inverting",
             {a_drv0, a_out0, b_drv0, b_out0},
             {e.ad, shape(e.ad, e.adat, 1'b1), e.bd, shape(e.bd, e.bdat, 1'b1)});
         cmp(e.tag, "non-inverting",
             {a_drv1, a_out1, b_drv1, b_out1},
             {e.ad, shape(e.ad, e.adat, 1'b0), e.bd, shape(e.bd, e.bdat, 1'b0)});
      end
   end

   // driver: sets controls, derives expectation from R4..R8, queues it
   task automatic step(string tag, logic oe, logic dir, logic sa, logic sbs,
                       logic [W-1:0] av, logic [W-1:0] bv);
      exp_t e;
      @(negedge clk);
      oe_n = oe; dir_to_b = dir; a_sel = sa; b_sel = sbs; a_ext = av; b_ext = bv;
      e.ad   = !oe && !dir;
      e.bd   = !oe && dir;
      e.adat = sa  ? mdl_ba : bv;
      e.bdat = sbs ? mdl_ab : av;
      e.tag  = tag;
      sb.push_back(e);
      @(posedge clk);
      #1;
   endtask

   task automatic pulse(bit do_ab, bit do_ba);
      @(negedge clk);
      #1;
      if (do_ab) begin clk_ab = 1'b1; mdl_ab = a_ext; end
      if (do_ba) begin clk_ba = 1'b1; mdl_ba = b_ext; end
      #1;
      clk_ab = 1'b0;
      clk_ba = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: registers read zero through stored selection
      step("R1", 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h66);
      step("R1", 1'b0, 1'b1, 1'b1, 1'b1, 8'h77, 8'h66);

      // R4 / R11: idle outputs, then capture on both sides while idle (R2, R3)
      step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5);
      pulse(1'b1, 1'b1);
      step("R11", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);

      // R3 / R5 / R7: A driven from stored BA, then live B
      step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
      step("R7", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h11);
      step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3);

      // R2 / R6 / R8: B driven from stored AB, then live A
      step("R2", 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
      step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h00);
      step("R6", 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00);

      // R2: capture A while B is driven, seen via stored path
      step("R2", 1'b0, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h00);
      pulse(1'b1, 1'b0);
      step("R2", 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F, 8'h00);

      // R3: capture B while A is driven from stored data
      step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h81);
      pulse(1'b0, 1'b1);
      step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h18);

      // R10: select flips with data held
      step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h18);
      step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

      // R1: asynchronous reset mid-run clears stored data
      @(negedge clk);
      rst_n = 1'b0;
      mdl_ab = '0;
      mdl_ba = '0;
      #1;
      rst_n = 1'b1;
      step("R1", 1'b0, 1'b1, 1'b0, 1'b1, 8'h99, 8'h99);
      step("R1", 1'b0, 1'b0, 1'b1, 1'b0, 8'h99, 8'h99);

      @(posedge clk);
      #1;
      done = 1'b1;
      report();
   end

endmodule